// File: doc/BRIEF.md
# Halfword-Aligning Instruction Fetch Queue

This block sits between instruction fetch and decode. Fetch pushes 32-bit words into a small queue. Decode receives one instruction at a time, either a 16-bit compressed one or a 32-bit one, and each may begin on any halfword. The block does not rewrite a stored address each time an instruction leaves. It keeps a two-state alignment tracker and one program-counter register. The tracker says whether the next instruction starts in the low or the high half of the word at the head of the queue.

Each delivered instruction carries its PC and an error bit. The error bit is set when any word that supplies bits of the instruction arrived marked as faulty. A 32-bit instruction may start in the high half of one word and end in the low half of the next. When the only faulty word is that second one, a separate flag is raised and the fault address output moves to PC + 2, so trap handling records the halfword that really failed.

The tracker has two states, `ST_ALIGNED` and `ST_UNALIGNED`, with these transitions:
- *compressed pop*: the state toggles.
- *full-length pop*: the state is kept.
- *flush*: the state is loaded from bit 1 of the new address.

Top module: `ffa_fetch_aligner`

## Requirements
- R1: After reset `out_valid_o` is low and `in_ready_o` is high.
- R2: An instruction whose bits [1:0] are 2'b11 is 32 bits long; any other value makes it a 16-bit instruction, delivered with `out_instr_o[31:16]` zero.
- R3: In `ST_ALIGNED` the instruction starts at bit 0 of the head word. In `ST_UNALIGNED` it starts at bit 16. A 32-bit instruction that starts at bit 16 takes its upper half from bits [15:0] of the next word.
- R4: An instruction that starts at bit 16 and is 32 bits long is not presented as valid until the next word is queued, unless the head word is faulty.
- R5: An instruction is accepted when `out_valid_o` and `out_ready_i` are both high. On acceptance `out_addr_o` advances by 2 for a 16-bit instruction and by 4 for a 32-bit one.
- R6: `flush_i` empties the queue and loads `flush_addr_i` into `out_addr_o`. Bit 1 of that address selects `ST_UNALIGNED` (1) or `ST_ALIGNED` (0). A word pushed in the flush cycle is discarded.
- R7: `out_err_o` is high when any word supplying bits of the presented instruction was pushed with `in_err_i` high.
- R8: `out_err_hi_o` is high only when a straddling 32-bit instruction is faulty solely because of its second word. `out_err_addr_o` then equals `out_addr_o` + 2.
- R9: If the head word is faulty, the instruction is presented as valid even when its second word has not arrived. In that case `out_err_o` is high, `out_err_hi_o` is low, and `out_err_addr_o` equals `out_addr_o`.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the instruction and its address stay unchanged, even if words are pushed.
- R11: With DEPTH words queued, `in_ready_o` is low and a pushed word is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue and restart at `flush_addr_i` |
| flush_addr_i | input | 32 | New fetch address |
| in_valid_i | input | 1 | A fetched word is offered |
| in_rdata_i | input | 32 | Fetched word |
| in_err_i | input | 1 | Fetched word is faulty |
| in_ready_o | output | 1 | Queue has room for a word |
| out_valid_o | output | 1 | An instruction is presented |
| out_ready_i | input | 1 | Decode accepts the instruction |
| out_instr_o | output | 32 | Instruction, upper half zero when compressed |
| out_addr_o | output | 32 | PC of the instruction |
| out_err_o | output | 1 | Instruction uses a faulty word |
| out_err_hi_o | output | 1 | Fault comes only from the second word of a straddling instruction |
| out_err_addr_o | output | 32 | Address to record for the fault |

## Verification
Every output is combinational from registered state. A word pushed at a clock edge, or an acceptance or a flush at an edge, therefore shows up on the outputs one cycle later and on no other cycle. The bench drives inputs and samples outputs at the falling edge. Each expected value is compared at the falling edge after the rising edge that should have produced it. In the vector table, row k therefore holds the push for row k and the outputs expected from the pushes of rows before it.

// File: rtl/ffa_pkg.sv
package ffa_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;

    typedef enum logic {
        ST_ALIGNED   = 1'b0,
        ST_UNALIGNED = 1'b1
    } align_state_e;

    typedef struct packed {
        logic              err;
        logic [WORD_W-1:0] data;
    } fetch_word_t;
endpackage

// File: rtl/ffa_word_fifo.sv
module ffa_word_fifo
    import ffa_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        clear_i,
    input  logic        push_i,
    input  fetch_word_t push_word_i,
    input  logic        pop_i,
    output logic        full_o,
    output logic        head_valid_o,
    output logic        next_valid_o,
    output fetch_word_t head_o,
    output fetch_word_t next_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = PTR_W + 1;

    fetch_word_t          mem_q [DEPTH];
    logic [PTR_W-1:0]     rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        ptr_inc = (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full_o       = (cnt_q == CNT_W'(DEPTH));
    assign head_valid_o = (cnt_q >= CNT_W'(1));
    assign next_valid_o = (cnt_q >= CNT_W'(2));
    assign head_o       = mem_q[rd_ptr_q];
    assign next_o       = mem_q[ptr_inc(rd_ptr_q)];
    assign do_push      = push_i && !full_o && !clear_i;
    assign do_pop       = pop_i && head_valid_o && !clear_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else if (clear_i) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                mem_q[g] <= '0;
            end else if (do_push && (wr_ptr_q == PTR_W'(g))) begin
                mem_q[g] <= push_word_i;
            end
        end
    end
endmodule

// File: rtl/ffa_instr_extract.sv
module ffa_instr_extract
    import ffa_pkg::*;
(
    input  align_state_e      state_i,
    input  logic              head_valid_i,
    input  logic              next_valid_i,
    input  fetch_word_t       head_i,
    input  fetch_word_t       next_i,
    output logic              valid_o,
    output logic              is_full_o,
    output logic [WORD_W-1:0] instr_o,
    output logic              err_o,
    output logic              err_hi_o
);
    logic [HALF_W-1:0] first_half;
    logic [HALF_W-1:0] second_half;
    logic              full_len;

    always_comb begin
        first_half  = '0;
        second_half = '0;
        valid_o     = 1'b0;
        err_o       = 1'b0;
        err_hi_o    = 1'b0;
        unique case (state_i)
            ST_ALIGNED: begin
                first_half  = head_i.data[HALF_W-1:0];
                second_half = head_i.data[WORD_W-1:HALF_W];
                valid_o     = head_valid_i;
                err_o       = head_i.err;
            end
            ST_UNALIGNED: begin
                first_half  = head_i.data[WORD_W-1:HALF_W];
                second_half = (next_valid_i && !head_i.err) ? next_i.data[HALF_W-1:0] : '0;
                valid_o     = head_valid_i &&
                              ((first_half[1:0] != 2'b11) || next_valid_i || head_i.err);
                err_o       = head_i.err ||
                              ((first_half[1:0] == 2'b11) && next_valid_i && next_i.err);
                err_hi_o    = (first_half[1:0] == 2'b11) && !head_i.err &&
                              next_valid_i && next_i.err;
            end
            default: ;
        endcase
        full_len  = (first_half[1:0] == 2'b11);
        is_full_o = full_len;
        instr_o   = full_len ? {second_half, first_half} : {{HALF_W{1'b0}}, first_half};
    end
endmodule

// File: rtl/ffa_align_fsm.sv
module ffa_align_fsm
    import ffa_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic [WORD_W-1:0] flush_addr_i,
    input  logic              accept_i,
    input  logic              is_full_i,
    output align_state_e      state_o,
    output logic [WORD_W-1:0] addr_o,
    output logic              pop_word_o
);
    align_state_e      state_q, state_d;
    logic [WORD_W-1:0] addr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_ALIGNED;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        pop_word_o = 1'b0;
        unique case (state_q)
            ST_ALIGNED: begin
                if (accept_i) begin
                    pop_word_o = is_full_i;
                    if (!is_full_i) state_d = ST_UNALIGNED;
                end
            end
            ST_UNALIGNED: begin
                if (accept_i) begin
                    pop_word_o = 1'b1;
                    if (!is_full_i) state_d = ST_ALIGNED;
                end
            end
            default: state_d = ST_ALIGNED;
        endcase
        if (flush_i) begin
            pop_word_o = 1'b0;
            state_d    = flush_addr_i[1] ? ST_UNALIGNED : ST_ALIGNED;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       addr_q <= '0;
        else if (flush_i)  addr_q <= flush_addr_i;
        else if (accept_i) addr_q <= addr_q + (is_full_i ? WORD_W'(4) : WORD_W'(2));
    end

    assign state_o = state_q;
    assign addr_o  = addr_q;
endmodule

// File: rtl/ffa_fetch_aligner.sv
module ffa_fetch_aligner
    import ffa_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        flush_i,
    input  logic [31:0] flush_addr_i,
    input  logic        in_valid_i,
    input  logic [31:0] in_rdata_i,
    input  logic        in_err_i,
    output logic        in_ready_o,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic [31:0] out_instr_o,
    output logic [31:0] out_addr_o,
    output logic        out_err_o,
    output logic        out_err_hi_o,
    output logic [31:0] out_err_addr_o
);
    fetch_word_t  head_w, next_w, push_w;
    logic         head_v, next_v, full, pop_word, accept, is_full;
    align_state_e state;

    assign push_w = '{err: in_err_i, data: in_rdata_i};
    assign accept = out_valid_o && out_ready_i && !flush_i;

    ffa_word_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .clear_i      (flush_i),
        .push_i       (in_valid_i),
        .push_word_i  (push_w),
        .pop_i        (pop_word),
        .full_o       (full),
        .head_valid_o (head_v),
        .next_valid_o (next_v),
        .head_o       (head_w),
        .next_o       (next_w)
    );

    ffa_instr_extract u_extract (
        .state_i      (state),
        .head_valid_i (head_v),
        .next_valid_i (next_v),
        .head_i       (head_w),
        .next_i       (next_w),
        .valid_o      (out_valid_o),
        .is_full_o    (is_full),
        .instr_o      (out_instr_o),
        .err_o        (out_err_o),
        .err_hi_o     (out_err_hi_o)
    );

    ffa_align_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .accept_i     (accept),
        .is_full_i    (is_full),
        .state_o      (state),
        .addr_o       (out_addr_o),
        .pop_word_o   (pop_word)
    );

    assign in_ready_o     = !full;
    assign out_err_addr_o = out_err_hi_o ? out_addr_o + 32'd2 : out_addr_o;
endmodule

// File: rtl/ffa_fetch_aligner_chk.sv
module ffa_fetch_aligner_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        flush_i,
    input logic [31:0] flush_addr_i,
    input logic        in_valid_i,
    input logic        in_ready_o,
    input logic        out_valid_o,
    input logic        out_ready_i,
    input logic [31:0] out_instr_o,
    input logic [31:0] out_addr_o,
    input logic        out_err_o,
    input logic        out_err_hi_o,
    input logic [31:0] out_err_addr_o
);
    AST_COMPRESSED_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_instr_o[1:0] != 2'b11) |-> (out_instr_o[31:16] == 16'h0)); // R2

    AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_ready_i && !flush_i) |=>
        (out_addr_o == $past(out_addr_o) + (($past(out_instr_o[1:0]) == 2'b11) ? 32'd4 : 32'd2))); // R5

    AST_FLUSH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (!out_valid_o && in_ready_o && out_addr_o == $past(flush_addr_i))); // R6

    AST_HI_ERR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_err_hi_o |-> (out_valid_o && out_err_o && out_err_addr_o == out_addr_o + 32'd2)); // R8

    AST_LO_ERR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_err_o && !out_err_hi_o) |-> (out_err_addr_o == out_addr_o)); // R9

    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i && !flush_i) |=>
        (out_valid_o && $stable(out_instr_o) && $stable(out_addr_o) && $stable(out_err_o))); // R10

    AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_ready_o && !flush_i && !(out_valid_o && out_ready_i)) |=> !in_ready_o); // R11
endmodule

bind ffa_fetch_aligner ffa_fetch_aligner_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (flush_i),
    .flush_addr_i   (flush_addr_i),
    .in_valid_i     (in_valid_i),
    .in_ready_o     (in_ready_o),
    .out_valid_o    (out_valid_o),
    .out_ready_i    (out_ready_i),
    .out_instr_o    (out_instr_o),
    .out_addr_o     (out_addr_o),
    .out_err_o      (out_err_o),
    .out_err_hi_o   (out_err_hi_o),
    .out_err_addr_o (out_err_addr_o)
);

// File: tb/ffa_fetch_aligner_tb_top.sv
`timescale 1ns/1ps
module ffa_fetch_aligner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] flush_addr = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_rdata = '0;
    logic        in_err = 1'b0;
    logic        in_ready, out_valid, out_err, out_err_hi;
    logic        out_ready = 1'b1;
    logic [31:0] out_instr, out_addr, out_err_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ffa_fetch_aligner #(.DEPTH(4)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .flush_addr_i(flush_addr),
        .in_valid_i(in_valid), .in_rdata_i(in_rdata), .in_err_i(in_err),
        .in_ready_o(in_ready), .out_valid_o(out_valid), .out_ready_i(out_ready),
        .out_instr_o(out_instr), .out_addr_o(out_addr), .out_err_o(out_err),
        .out_err_hi_o(out_err_hi), .out_err_addr_o(out_err_addr)
    );

    typedef struct packed {
        logic        push;
        logic [31:0] word;
        logic        werr;
        logic        ev;
        logic [31:0] einstr;
        logic [31:0] eaddr;
        logic        eerr;
        logic        ehi;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 32'h8A5A0001, 1'b0, 1'b0, 32'h0,        32'h0,   1'b0, 1'b0},
        '{1'b1, 32'h00C58593, 1'b0, 1'b1, 32'h00000001, 32'h100, 1'b0, 1'b0},
        '{1'b1, 32'h05134502, 1'b0, 1'b1, 32'h00008A5A, 32'h102, 1'b0, 1'b0},
        '{1'b1, 32'h80820010, 1'b0, 1'b1, 32'h00C58593, 32'h104, 1'b0, 1'b0},
        '{1'b0, 32'h0,        1'b0, 1'b1, 32'h00004502, 32'h108, 1'b0, 1'b0},
        '{1'b0, 32'h0,        1'b0, 1'b1, 32'h00100513, 32'h10A, 1'b0, 1'b0},
        '{1'b0, 32'h0,        1'b0, 1'b1, 32'h00008082, 32'h10E, 1'b0, 1'b0},
        '{1'b1, 32'hFFFF0513, 1'b1, 1'b0, 32'h0,        32'h0,   1'b0, 1'b0},
        '{1'b1, 32'h05130001, 1'b0, 1'b1, 32'hFFFF0513, 32'h110, 1'b1, 1'b0},
        '{1'b1, 32'h777400AB, 1'b1, 1'b1, 32'h00000001, 32'h114, 1'b0, 1'b0},
        '{1'b0, 32'h0,        1'b0, 1'b1, 32'h00AB0513, 32'h116, 1'b1, 1'b1},
        '{1'b0, 32'h0,        1'b0, 1'b1, 32'h00007774, 32'h11A, 1'b1, 1'b0},
        '{1'b0, 32'h0,        1'b0, 1'b0, 32'h0,        32'h0,   1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // full output check; expected values follow R2/R3/R7/R8/R9
    task automatic check_out(input string req, input logic ev, input logic [31:0] ei,
                             input logic [31:0] ea, input logic ee, input logic eh);
        check({req, " valid"}, {31'b0, out_valid}, {31'b0, ev});
        if (ev) begin
            check({req, " instr"}, out_instr, ei);
            check({req, " addr"}, out_addr, ea);
            check({req, " err"}, {31'b0, out_err}, {31'b0, ee});
            check({req, " err_hi"}, {31'b0, out_err_hi}, {31'b0, eh});
            if (ee) check({req, " err_addr"}, out_err_addr, eh ? ea + 32'd2 : ea);
        end
    endtask

    task automatic drive(input logic f, input logic [31:0] fa, input logic p,
                         input logic [31:0] w, input logic e);
        flush = f; flush_addr = fa; in_valid = p; in_rdata = w; in_err = e;
    endtask

    task automatic next_neg();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) next_neg();
        // R1: reset state
        check("R1 valid", {31'b0, out_valid}, 32'd0);
        check("R1 ready", {31'b0, in_ready}, 32'd1);
        rst_n = 1'b1;
        next_neg();
        check("R1 valid after release", {31'b0, out_valid}, 32'd0);

        // vector table: R2 R3 R5 R7 R8
        drive(1'b1, 32'h100, 1'b0, 32'h0, 1'b0);
        next_neg();
        for (int k = 0; k < NV; k++) begin
            check_out($sformatf("R2/R3/R5/R7/R8 row%0d", k), TBL[k].ev, TBL[k].einstr,
                      TBL[k].eaddr, TBL[k].eerr, TBL[k].ehi);
            drive(1'b0, 32'h0, TBL[k].push, TBL[k].word, TBL[k].werr);
            next_neg();
        end

        // R4: straddling instruction waits for second word
        drive(1'b1, 32'h202, 1'b0, 32'h0, 1'b0);
        next_neg();
        drive(1'b0, 32'h0, 1'b1, 32'h05130000, 1'b0);
        next_neg();
        check_out("R4 wait", 1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
        drive(1'b0, 32'h0, 1'b1, 32'h000000AB, 1'b0);
        next_neg();
        check_out("R4 complete", 1'b1, 32'h00AB0513, 32'h202, 1'b0, 1'b0);

        // R9: faulty first word, no second word yet
        drive(1'b1, 32'h302, 1'b0, 32'h0, 1'b0);
        next_neg();
        drive(1'b0, 32'h0, 1'b1, 32'h05130000, 1'b1);
        next_neg();
        check_out("R9 first-half err", 1'b1, 32'h00000513, 32'h302, 1'b1, 1'b0);
        check("R9 err_addr", out_err_addr, 32'h302);

        // R6: flush discards concurrent push, loads address
        drive(1'b1, 32'h400, 1'b1, 32'h00000001, 1'b0);
        next_neg();
        drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
        check("R6 empty after flush", {31'b0, out_valid}, 32'd0);
        check("R6 addr loaded", out_addr, 32'h400);
        check("R6 ready after flush", {31'b0, in_ready}, 32'd1);
        next_neg();
        check("R6 push in flush dropped", {31'b0, out_valid}, 32'd0);
        drive(1'b1, 32'h402, 1'b0, 32'h0, 1'b0);
        next_neg();
        drive(1'b0, 32'h0, 1'b1, 32'h00020001, 1'b0);
        next_neg();
        drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
        check_out("R6 unaligned start", 1'b1, 32'h00000002, 32'h402, 1'b0, 1'b0);

        // R10 stall hold, R11 full
        out_ready = 1'b0;
        drive(1'b1, 32'h500, 1'b0, 32'h0, 1'b0);
        next_neg();
        drive(1'b0, 32'h0, 1'b1, 32'h00110013, 1'b0);
        next_neg();
        for (int k = 2; k <= 4; k++) begin
            check_out($sformatf("R10 hold %0d", k), 1'b1, 32'h00110013, 32'h500, 1'b0, 1'b0);
            drive(1'b0, 32'h0, 1'b1, 32'h00100013 + (32'(k) << 16), 1'b0);
            next_neg();
        end
        check("R11 ready low when full", {31'b0, in_ready}, 32'd0);
        drive(1'b0, 32'h0, 1'b1, 32'h00150013, 1'b0);
        next_neg();
        drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
        out_ready = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            check_out($sformatf("R11 drain %0d", k), 1'b1, 32'h00100013 + (32'(k) << 16),
                      32'h500 + 32'(4 * (k - 1)), 1'b0, 1'b0);
            next_neg();
        end
        check("R11 extra word ignored", {31'b0, out_valid}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule